// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter with a three-and-a-half digit result. It runs on the converter oscillator and divides it by four to form a count clock. On that count clock it drives the analog switch controls through three phases in a fixed loop: auto-zero, signal integrate and reference deintegrate. At the end of signal integrate it reads a comparator to learn the input sign, and it closes the reference switch pair that drives the integrator back toward zero.

During deintegrate, cascaded decimal counters accumulate count periods until the synchronized comparator reports the zero crossing, or until the window limit of 2000 counts is reached. The count is then copied to a held output together with a polarity flag and an over-range flag, and a one-cycle strobe marks the new result. Auto-zero takes whatever remains of the deintegrate window, so every conversion spans 4000 count periods whatever the input. The analog integrator, the comparator and the reference are outside the block.

Top module: `dualslope_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters auto-zero: `swAz` is 1, the other three switch outputs are 0, and `result`, `polarity`, `overRange` and `resultValid` are all 0.
- R2: Signal integrate (`swInt` high) lasts exactly 1000 count periods, that is 4000 `clk` cycles, because one count period is four `clk` cycles.
- R3: For a comparator change that becomes visible after N completed deintegrate count periods, deintegrate lasts N+1 count periods (4*(N+1) `clk` cycles) and the reading is N.
- R4: The start of one signal integrate and the start of the next are always 16000 `clk` cycles apart, whatever the reading.
- R5: Exactly one switch output is high at any time, and the phases run in the order auto-zero, signal integrate, deintegrate, auto-zero.
- R6: `cmpIn` high at the end of signal integrate marks a positive input and selects `swDePos`; `cmpIn` low marks a negative input and selects `swDeNeg`. Deintegrate ends when the synchronized comparator differs from that captured value.
- R7: `polarity` is 1 for a negative input and 0 for a positive one, including when the reading is zero.
- R8: `result` is packed decimal: units in bits [3:0], tens in [7:4], hundreds in [11:8], thousands in [15:12]. It, `polarity` and `overRange` change only together with a `resultValid` pulse that lasts one `clk` cycle, so a partial count is never shown.
- R9: If the comparator has not changed by the time 2000 counts are accumulated, deintegrate ends after 2001 count periods with `result` 2000 and `overRange` 1. `overRange` is 0 for any reading ended by the comparator.
- R10: A reset applied in the middle of a conversion restarts the loop at auto-zero with the counters cleared, and the next conversion gives a correct reading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | 1 | Asynchronous comparator output, high when the integrator holds a positive-input charge |
| swAz | output | 1 | Auto-zero switch control |
| swInt | output | 1 | Signal integrate switch control |
| swDePos | output | 1 | Deintegrate switch pair for a positive input |
| swDeNeg | output | 1 | Deintegrate switch pair for a negative input |
| result | output | 16 | Held packed-decimal reading |
| polarity | output | 1 | Held sign, 1 for a negative input |
| overRange | output | 1 | Held flag, 1 when the deintegrate window ran out |
| resultValid | output | 1 | One-cycle strobe when a new reading is held |

## Verification
The comparator is modelled as a step that the bench places a chosen number of count periods into deintegrate, so each reading is exactly known. Readings of zero with either sign separate the polarity capture from the count itself; 7, 10 and 999 show the carry ripple between decades; 123 and 1999 with a negative input exercise the other switch pair and the top of the range. A conversion where the comparator never changes exercises the window limit, and a reset in the middle of integrate shows the restart and the cleared counters. Each conversion also measures the integrate and deintegrate lengths and the spacing between conversions, which separates a count taken at the wrong tick from a reading that is merely latched late.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

  typedef enum logic [1:0] {
    PH_AZ  = 2'd0,
    PH_INT = 2'd1,
    PH_DE  = 2'd2
  } phase_e;

  // Strobes from control to datapath, all valid for one clk cycle.
  typedef struct packed {
    logic clrCnt;    // clear the decade counters (entering deintegrate)
    logic incCnt;    // advance the decade counters by one count
    logic latchRes;  // copy the counters to the held result
    logic overHit;   // the result being latched ran out of window
    logic negIn;     // captured input sign is negative
  } dpStrobe_t;

  // Packed-decimal form of a non-negative integer, eight digits.
  function automatic logic [31:0] toBcd(input int value);
    logic [31:0] r;
    int v;
    r = '0;
    v = value;
    for (int i = 0; i < 8; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe <= {pipe[STAGES-2:0], dIn};
    end
  end

  assign dOut = pipe[STAGES-1];

endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
  import dsq_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int INT_CNT = 1000,
  parameter int DE_MAX  = 2000,
  parameter int CYCLE   = 4000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cmpSync,
  input  logic      atLimit,
  output dpStrobe_t strobe,
  output logic      swAz,
  output logic      swInt,
  output logic      swDePos,
  output logic      swDeNeg
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CYC_W = $clog2(CYCLE);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(DIV - 1);
  localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(CYCLE - 1);
  localparam logic [CYC_W-1:0] INT_LAST  = CYC_W'(INT_CNT - 1);
  // Reset lands where a maximal deintegrate would end: the shortest auto-zero.
  localparam logic [CYC_W-1:0] CYC_START = CYC_W'(INT_CNT + DE_MAX);

  logic [DIV_W-1:0] divCnt;
  logic [CYC_W-1:0] cycCnt;
  phase_e           phase, phaseNext;
  logic             signPos;
  logic             tick;
  logic             intEnd;
  logic             zeroHit;
  logic             deEnd;

  assign tick    = (divCnt == DIV_LAST);
  assign intEnd  = (phase == PH_INT) && (cycCnt == INT_LAST);
  assign zeroHit = (cmpSync != signPos);
  assign deEnd   = (phase == PH_DE) && (zeroHit || atLimit);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_AZ:   if (cycCnt == CYC_LAST) phaseNext = PH_INT;
      PH_INT:  if (intEnd)             phaseNext = PH_DE;
      PH_DE:   if (deEnd)              phaseNext = PH_AZ;
      default:                         phaseNext = PH_AZ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      cycCnt  <= CYC_START;
      phase   <= PH_AZ;
      signPos <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        cycCnt <= (cycCnt == CYC_LAST) ? '0 : cycCnt + 1'b1;
        phase  <= phaseNext;
        if (intEnd) begin
          signPos <= cmpSync;
        end
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clrCnt   = tick && intEnd;
    strobe.incCnt   = tick && (phase == PH_DE) && !zeroHit && !atLimit;
    strobe.latchRes = tick && deEnd;
    strobe.overHit  = atLimit && !zeroHit;
    strobe.negIn    = !signPos;
  end

  assign swAz    = (phase == PH_AZ);
  assign swInt   = (phase == PH_INT);
  assign swDePos = (phase == PH_DE) && signPos;
  assign swDeNeg = (phase == PH_DE) && !signPos;

endmodule

// File: rtl/dsq_datapath.sv
module dsq_datapath
  import dsq_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int DE_MAX = 2000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobe_t             strobe,
  output logic                  atLimit,
  output logic [4*DIGITS-1:0]   result,
  output logic                  polarity,
  output logic                  overRange,
  output logic                  resultValid
);

  localparam int W = 4 * DIGITS;
  localparam logic [31:0]  LIM32 = toBcd(DE_MAX);
  localparam logic [W-1:0] LIM   = LIM32[W-1:0];

  logic [W-1:0]        cnt;
  logic [W-1:0]        cntNext;
  logic [DIGITS-1:0]   carry;

  assign carry[0] = strobe.incCnt;

  generate
    for (genvar d = 0; d < DIGITS; d++) begin : g_dec
      logic [3:0] cur;
      assign cur = cnt[4*d +: 4];
      assign cntNext[4*d +: 4] = !carry[d]     ? cur :
                                 (cur == 4'd9) ? 4'd0 : cur + 4'd1;
      if (d < DIGITS - 1) begin : g_carry
        assign carry[d+1] = carry[d] && (cur == 4'd9);
      end
    end
  endgenerate

  assign atLimit = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      result      <= '0;
      polarity    <= 1'b0;
      overRange   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.latchRes;
      if (strobe.clrCnt) begin
        cnt <= '0;
      end else begin
        cnt <= cntNext;
      end
      if (strobe.latchRes) begin
        result    <= cnt;
        polarity  <= strobe.negIn;
        overRange <= strobe.overHit;
      end
    end
  end

endmodule

// File: rtl/dualslope_seq.sv
module dualslope_seq
  import dsq_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int INT_CNT = 1000,
  parameter int DE_MAX  = 2000,
  parameter int CYCLE   = 4000,
  parameter int DIGITS  = 4,
  parameter int SYNC_N  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmpIn,
  output logic                swAz,
  output logic                swInt,
  output logic                swDePos,
  output logic                swDeNeg,
  output logic [4*DIGITS-1:0] result,
  output logic                polarity,
  output logic                overRange,
  output logic                resultValid
);

  logic      cmpSync;
  logic      atLimit;
  dpStrobe_t strobe;

  dsq_sync #(.STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .dIn  (cmpIn),
    .dOut (cmpSync)
  );

  dsq_ctrl #(
    .DIV     (DIV),
    .INT_CNT (INT_CNT),
    .DE_MAX  (DE_MAX),
    .CYCLE   (CYCLE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmpSync (cmpSync),
    .atLimit (atLimit),
    .strobe  (strobe),
    .swAz    (swAz),
    .swInt   (swInt),
    .swDePos (swDePos),
    .swDeNeg (swDeNeg)
  );

  dsq_datapath #(
    .DIGITS (DIGITS),
    .DE_MAX (DE_MAX)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .atLimit     (atLimit),
    .result      (result),
    .polarity    (polarity),
    .overRange   (overRange),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/dualslope_seq_chk.sv
module dualslope_seq_chk
  import dsq_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int DE_MAX = 2000
) (
  input logic                clk,
  input logic                rst,
  input logic                swAz,
  input logic                swInt,
  input logic                swDePos,
  input logic                swDeNeg,
  input logic [4*DIGITS-1:0] result,
  input logic                polarity,
  input logic                overRange,
  input logic                resultValid
);

  localparam logic [31:0] LIM32 = toBcd(DE_MAX);
  localparam logic [4*DIGITS-1:0] LIM = LIM32[4*DIGITS-1:0];

  // R5
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({swAz, swInt, swDePos, swDeNeg}));

  // R5
  int_after_az_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(swInt) |-> $past(swAz));

  // R5
  de_after_int_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(swDePos || swDeNeg) |-> $past(swInt));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  // R8
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> (swAz && ($past(swDePos) || $past(swDeNeg))));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> ($stable(result) && $stable(polarity) && $stable(overRange)));

  // R9
  over_value_chk: assert property (@(posedge clk) disable iff (rst)
    overRange |-> (result == LIM));

endmodule

bind dualslope_seq dualslope_seq_chk #(
  .DIGITS (DIGITS),
  .DE_MAX (DE_MAX)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .swAz        (swAz),
  .swInt       (swInt),
  .swDePos     (swDePos),
  .swDeNeg     (swDeNeg),
  .result      (result),
  .polarity    (polarity),
  .overRange   (overRange),
  .resultValid (resultValid)
);

// File: tb/dualslope_seq_bench.sv
module dualslope_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmpIn;
  logic        swAz, swInt, swDePos, swDeNeg;
  logic [15:0] result;
  logic        polarity, overRange, resultValid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lastStart = 0;
  bit haveLast  = 1'b0;
  logic [15:0] prevResult = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dualslope_seq u_dualslope_seq (
    .clk         (clk),
    .rst         (rst),
    .cmpIn       (cmpIn),
    .swAz        (swAz),
    .swInt       (swInt),
    .swDePos     (swDePos),
    .swDeNeg     (swDeNeg),
    .result      (result),
    .polarity    (polarity),
    .overRange   (overRange),
    .resultValid (resultValid)
  );

  // {positive input, reading}
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 16'd0},
    {1'b0, 16'd0},
    {1'b1, 16'd7},
    {1'b1, 16'd10},
    {1'b0, 16'd123},
    {1'b1, 16'd999},
    {1'b0, 16'd1999}
  };

  function automatic logic [15:0] bcd4(input int v);
    logic [15:0] r;
    int x;
    x = v;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runConv(input bit pos, input int n, input bit over);
    int tStart, len, c0, expN;
    expN = over ? 2000 : n;
    while (!swInt) @(negedge clk);
    tStart = cyc;
    if (haveLast) check((tStart - lastStart) == 16000, "R4", "cycle spacing", tStart - lastStart, 16000);
    lastStart = tStart;
    haveLast  = 1'b1;
    cmpIn = pos;
    len = 0;
    while (swInt) begin
      len++;
      @(negedge clk);
    end
    check(len == 4000, "R2", "integrate length", len, 4000);
    check(swDePos == pos && swDeNeg == !pos, "R6", "switch pair {pos,neg}",
          {swDePos, swDeNeg}, {pos, !pos});
    check(result == prevResult && !resultValid, "R8", "held result at deintegrate start",
          result, prevResult);
    c0 = cyc;
    if (!over) begin
      repeat (4 * n) @(posedge clk);
      @(negedge clk);
      cmpIn = !pos;
    end
    while (!resultValid) @(negedge clk);
    if (over)
      check((cyc - c0) == 4 * 2001, "R9", "deintegrate length at limit", cyc - c0, 4 * 2001);
    else
      check((cyc - c0) == 4 * (n + 1), "R3", "deintegrate length", cyc - c0, 4 * (n + 1));
    check(result == bcd4(expN), over ? "R9" : "R3", "reading", result, bcd4(expN));
    check(polarity == !pos, "R7", "polarity", polarity, !pos);
    check(overRange == over, "R9", "over-range flag", overRange, over);
    prevResult = result;
    @(negedge clk);
    check(!resultValid && result == prevResult, "R8", "strobe width / hold", resultValid, 0);
  endtask

  initial begin
    rst   = 1'b1;
    cmpIn = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(swAz && !swInt && !swDePos && !swDeNeg, "R1", "switches after reset",
          {swAz, swInt, swDePos, swDeNeg}, 4'b1000);
    check(result == 16'h0 && !polarity && !overRange && !resultValid, "R1", "outputs after reset",
          result, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      runConv(VEC[i][16], int'(VEC[i][15:0]), 1'b0);
    end

    // R9 comparator never crosses
    runConv(1'b0, 0, 1'b1);

    // R10 reset in the middle of integrate
    while (!swInt) @(negedge clk);
    repeat (100) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(swAz && !swInt && !swDePos && !swDeNeg, "R1", "switches after mid-run reset",
          {swAz, swInt, swDePos, swDeNeg}, 4'b1000);
    check(result == 16'h0 && !polarity && !overRange && !resultValid, "R1", "outputs after mid-run reset",
          result, 0);
    rst = 1'b0;
    haveLast   = 1'b0;
    prevResult = '0;
    runConv(1'b1, 1000, 1'b0); // R10 first reading after restart

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule